// File: doc/BRIEF.md
# Serial Presence Detect Command Decoder

This block interprets the first byte that follows a start condition on the management bus of a 512-byte serial presence detect memory. A separate bit engine shifts bytes in and drives the acknowledge slot. This block tells that engine, byte by byte, whether to acknowledge. It sorts each select byte into one of two groups: ordinary accesses to the memory array, or commands that set, clear or query the per-block write protection and the page select. For the query commands, the answer is the acknowledge itself.

The block keeps four protection bits, one for each 128-byte block, and a single page bit that chooses the lower or upper 256 bytes. A block is named by the page bit followed by bit 7 of the byte address. A byte engine reports each received byte with a one-cycle strobe, plus a strobe for the stop condition. The block answers every strobe one clock later with a response pulse and an acknowledge level. When a stop arrives, it raises a write-cycle request for any write that was accepted.

Top module: `spd_cmd_decoder`

## Requirements
- R1: A select byte with upper nibble 1010 is acknowledged only when bits 3..1 equal `slave_addr_i`; any other nibble than 1010 or 0110 gets noack. Every select byte gets noack while `write_busy_i` is high, and it then changes neither page nor protection.
- R2: Under upper nibble 0110 with bit 0 (R/W) = 0 and `hv_i` high, codes in bits 3..1 of 001, 100, 101 and 000 set protection on blocks 0, 1, 2 and 3 (`prot_o` bits 0..3). When the block is unprotected, the select, address and data bytes are each acknowledged, and a stop after the data byte sets the bit and pulses `wr_req_o`.
- R3: A set-protect command aimed at a block that is already protected gets noack on the select, address and data bytes, and the following stop gives no `wr_req_o`.
- R4: Set-protect and clear-all commands (R/W = 0, codes 001, 100, 101, 000, 011) that arrive with `hv_i` low get noack and leave `prot_o` unchanged.
- R5: Code 011 with R/W = 0 and `hv_i` high acknowledges all three bytes. A stop after the data byte clears all four protection bits at once and pulses `wr_req_o`.
- R6: Under nibble 0110 with R/W = 1, the four block codes query a block. The select byte gets ack when that block is unprotected and noack when it is protected, whatever the level of `hv_i`.
- R7: Under nibble 0110, code 110 with R/W = 0 sets the page to 0 and code 111 with R/W = 0 sets it to 1; both are acknowledged. Code 110 with R/W = 1 gets ack when the page is 0 and noack when it is 1. The page is 0 after reset.
- R8: A data byte of a memory write is acknowledged only when `wr_ctrl_i` is low and block {page, byte address bit 7} is unprotected. A stop after an acknowledged data byte pulses `wr_req_o`.
- R9: The remaining encodings under nibble 0110 (code 010 with either R/W value; codes 011 and 111 with R/W = 1) get noack.
- R10: After reset `prot_o` equals the parameter `PROT_INIT`. A stop pulses `wr_req_o` only if a write data byte was acknowledged since the last select byte.
- R11: Each byte strobe is answered exactly one clock later by a one-cycle `resp_o` pulse, with `ack_o` valid in that cycle. `resp_o` never pulses without a preceding strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_valid_i | input | 1 | Strobe: select byte received |
| sel_byte_i | input | 8 | Received select byte, bit 0 is R/W |
| addr_valid_i | input | 1 | Strobe: address byte received |
| addr_msb_i | input | 1 | Bit 7 of the received byte address |
| data_valid_i | input | 1 | Strobe: data byte received |
| stop_i | input | 1 | Strobe: stop condition seen |
| slave_addr_i | input | 3 | Strapped device address |
| hv_i | input | 1 | High voltage detected on address pin 0 |
| write_busy_i | input | 1 | Internal write cycle in progress |
| wr_ctrl_i | input | 1 | High blocks writes to the memory array |
| resp_o | output | 1 | Response valid, one cycle after a byte strobe |
| ack_o | output | 1 | 1 = acknowledge, 0 = noack |
| wr_req_o | output | 1 | Pulse: start an internal write cycle |
| page_o | output | 1 | Current page select |
| prot_o | output | 4 | Write-protect bit of each block |

## Verification
The assertions hold on every cycle for several rules: noack while busy, no acknowledge for protection writes without the high-voltage flag, a memory data noack under write control, protection bits that change only together with a write request at a stop, a page bit that changes only after a page command, and a response only after a strobe. Other behaviour can only be shown by the bench's scenarios. This covers the exact code-to-block mapping, the ack-means-unprotected polarity of the queries, and the three-byte noack for an already protected block. It also covers the block chosen by page and address bit, and a full sweep of all 256 select bytes under both levels of the voltage flag.

// File: rtl/spd_cmd_pkg.sv
package spd_cmd_pkg;

    localparam int NUM_BLK = 4;
    localparam int BLK_W   = $clog2(NUM_BLK);

    localparam logic [3:0] MEM_NIBBLE = 4'b1010;
    localparam logic [3:0] CMD_NIBBLE = 4'b0110;

    localparam logic [2:0] CODE_CLR  = 3'b011;
    localparam logic [2:0] CODE_PG0  = 3'b110;
    localparam logic [2:0] CODE_PG1  = 3'b111;

    typedef enum logic [3:0] {
        K_NONE,
        K_MEM_WR,
        K_MEM_RD,
        K_WP_SET,
        K_WP_CLR,
        K_WP_QRY,
        K_PG0,
        K_PG1,
        K_PG_QRY,
        K_RSVD
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e        kind;
        logic [BLK_W-1:0] blk;
    } sel_dec_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_MEM_WR,
        OP_MEM_RD,
        OP_WP_SET,
        OP_WP_CLR,
        OP_WP_REJ
    } op_e;

    // Block codes are not binary: the mapping is kept for compatibility.
    function automatic logic code_is_blk(input logic [2:0] code);
        return (code == 3'b001) || (code == 3'b100) ||
               (code == 3'b101) || (code == 3'b000);
    endfunction

    function automatic logic [BLK_W-1:0] code_to_blk(input logic [2:0] code);
        logic [BLK_W-1:0] b;
        case (code)
            3'b001:  b = 2'd0;
            3'b100:  b = 2'd1;
            3'b101:  b = 2'd2;
            default: b = 2'd3;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/spd_sel_classify.sv
module spd_sel_classify
    import spd_cmd_pkg::*;
(
    input  logic [7:0] sel_byte_i,
    input  logic [2:0] slave_addr_i,
    output sel_dec_t   dec_o
);

    logic [3:0] nib;
    logic [2:0] code;
    logic       rw;

    assign nib  = sel_byte_i[7:4];
    assign code = sel_byte_i[3:1];
    assign rw   = sel_byte_i[0];

    always_comb begin
        dec_o.kind = K_NONE;
        dec_o.blk  = code_to_blk(code);
        if (nib == MEM_NIBBLE) begin
            if (code == slave_addr_i)
                dec_o.kind = rw ? K_MEM_RD : K_MEM_WR;
        end else if (nib == CMD_NIBBLE) begin
            if (code_is_blk(code))
                dec_o.kind = rw ? K_WP_QRY : K_WP_SET;
            else if (code == CODE_CLR && !rw)
                dec_o.kind = K_WP_CLR;
            else if (code == CODE_PG0)
                dec_o.kind = rw ? K_PG_QRY : K_PG0;
            else if (code == CODE_PG1 && !rw)
                dec_o.kind = K_PG1;
            else
                dec_o.kind = K_RSVD;
        end
    end

endmodule

// File: rtl/spd_cmd_decoder.sv
module spd_cmd_decoder
    import spd_cmd_pkg::*;
#(
    parameter logic [NUM_BLK-1:0] PROT_INIT = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_valid_i,
    input  logic [7:0]         sel_byte_i,
    input  logic               addr_valid_i,
    input  logic               addr_msb_i,
    input  logic               data_valid_i,
    input  logic               stop_i,
    input  logic [2:0]         slave_addr_i,
    input  logic               hv_i,
    input  logic               write_busy_i,
    input  logic               wr_ctrl_i,
    output logic               resp_o,
    output logic               ack_o,
    output logic               wr_req_o,
    output logic               page_o,
    output logic [NUM_BLK-1:0] prot_o
);

    typedef struct packed {
        op_e                op;
        logic [BLK_W-1:0]   blk;
        logic               pend;
        logic               ack;
        logic               resp;
        logic               wr_req;
        logic               page;
        logic [NUM_BLK-1:0] prot;
    } state_t;

    state_t   st_d, st_q;
    sel_dec_t dec;

    spd_sel_classify u_classify (
        .sel_byte_i   (sel_byte_i),
        .slave_addr_i (slave_addr_i),
        .dec_o        (dec)
    );

    always_comb begin
        st_d        = st_q;
        st_d.resp   = 1'b0;
        st_d.wr_req = 1'b0;
        if (sel_valid_i) begin
            st_d.resp = 1'b1;
            st_d.ack  = 1'b0;
            st_d.pend = 1'b0;
            st_d.op   = OP_IDLE;
            if (!write_busy_i) begin
                case (dec.kind)
                    K_MEM_WR: begin st_d.ack = 1'b1; st_d.op = OP_MEM_WR; end
                    K_MEM_RD: begin st_d.ack = 1'b1; st_d.op = OP_MEM_RD; end
                    K_WP_SET: begin
                        st_d.blk = dec.blk;
                        if (hv_i && !st_q.prot[dec.blk]) begin
                            st_d.ack = 1'b1;
                            st_d.op  = OP_WP_SET;
                        end else if (hv_i) begin
                            st_d.op  = OP_WP_REJ;
                        end
                    end
                    K_WP_CLR: begin
                        if (hv_i) begin
                            st_d.ack = 1'b1;
                            st_d.op  = OP_WP_CLR;
                        end
                    end
                    K_WP_QRY: st_d.ack = !st_q.prot[dec.blk];
                    K_PG0:    begin st_d.ack = 1'b1; st_d.page = 1'b0; end
                    K_PG1:    begin st_d.ack = 1'b1; st_d.page = 1'b1; end
                    K_PG_QRY: st_d.ack = !st_q.page;
                    default:  st_d.ack = 1'b0;
                endcase
            end
        end else if (addr_valid_i) begin
            st_d.resp = 1'b1;
            st_d.ack  = (st_q.op == OP_MEM_WR) || (st_q.op == OP_WP_SET) ||
                        (st_q.op == OP_WP_CLR);
            if (st_q.op == OP_MEM_WR)
                st_d.blk = {st_q.page, addr_msb_i};
        end else if (data_valid_i) begin
            st_d.resp = 1'b1;
            case (st_q.op)
                OP_MEM_WR: begin
                    st_d.ack  = !wr_ctrl_i && !st_q.prot[st_q.blk];
                    st_d.pend = st_q.pend || st_d.ack;
                end
                OP_WP_SET, OP_WP_CLR: begin
                    st_d.ack  = 1'b1;
                    st_d.pend = 1'b1;
                end
                default: st_d.ack = 1'b0;
            endcase
        end else if (stop_i) begin
            if (st_q.pend) begin
                st_d.wr_req = 1'b1;
                if (st_q.op == OP_WP_SET)
                    st_d.prot[st_q.blk] = 1'b1;
                else if (st_q.op == OP_WP_CLR)
                    st_d.prot = '0;
            end
            st_d.pend = 1'b0;
            st_d.op   = OP_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.op     <= OP_IDLE;
            st_q.prot   <= PROT_INIT;
        end else begin
            st_q        <= st_d;
        end
    end

    assign resp_o   = st_q.resp;
    assign ack_o    = st_q.ack;
    assign wr_req_o = st_q.wr_req;
    assign page_o   = st_q.page;
    assign prot_o   = st_q.prot;

    AST_BUSY_NOACK: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_i && write_busy_i |=> resp_o && !ack_o); // R1

    AST_PROT_WITH_WRREQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_o) |-> wr_req_o && $past(stop_i)); // R2

    AST_NOHV_NOACK: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_i && !hv_i && sel_byte_i[7:4] == CMD_NIBBLE && !sel_byte_i[0] &&
        sel_byte_i[3:2] != 2'b11 |=> !ack_o); // R4

    AST_PAGE_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(page_o) |-> $past(sel_valid_i && !write_busy_i &&
        sel_byte_i[7:4] == CMD_NIBBLE && sel_byte_i[3:2] == 2'b11 && !sel_byte_i[0])); // R7

    AST_WC_MEM_NOACK: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_i && !sel_valid_i && !addr_valid_i && wr_ctrl_i &&
        st_q.op == OP_MEM_WR |=> !ack_o); // R8

    AST_WRREQ_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> $past(stop_i)); // R10

    AST_RESP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_o |-> $past(sel_valid_i || addr_valid_i || data_valid_i)); // R11

endmodule

// File: tb/spd_cmd_decoder_tb.sv
module spd_cmd_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_valid = 1'b0, addr_valid = 1'b0, data_valid = 1'b0, stop = 1'b0;
    logic [7:0] sel_byte = '0;
    logic       addr_msb = 1'b0;
    logic [2:0] slave_addr = 3'b101;
    logic       hv = 1'b0, busy = 1'b0, wc = 1'b0;
    logic       resp, ack, wr_req, page;
    logic [3:0] prot;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic       m_page = 1'b0;
    logic [3:0] m_prot = 4'b0000;

    always #10 clk = ~clk;

    spd_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .sel_valid_i(sel_valid), .sel_byte_i(sel_byte),
        .addr_valid_i(addr_valid), .addr_msb_i(addr_msb),
        .data_valid_i(data_valid), .stop_i(stop),
        .slave_addr_i(slave_addr), .hv_i(hv), .write_busy_i(busy),
        .wr_ctrl_i(wc),
        .resp_o(resp), .ack_o(ack), .wr_req_o(wr_req),
        .page_o(page), .prot_o(prot)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] blk_code(input int b);
        case (b)
            0: return 3'b001;
            1: return 3'b100;
            2: return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

    // Expected ack of a select byte, from the requirements alone.
    function automatic logic exp_sel(input logic [7:0] b);
        logic [2:0] c = b[3:1];
        logic r = b[0];
        int blk = -1;
        for (int i = 0; i < 4; i++) if (blk_code(i) == c) blk = i;
        if (busy) return 1'b0;
        if (b[7:4] == 4'b1010) return c == slave_addr;
        if (b[7:4] != 4'b0110) return 1'b0;
        if (blk >= 0) return r ? !m_prot[blk] : (hv && !m_prot[blk]);
        if (c == 3'b011) return !r && hv;
        if (c == 3'b110) return r ? !m_page : 1'b1;
        if (c == 3'b111) return !r;
        return 1'b0;
    endfunction

    task automatic strobe_sel(input logic [7:0] b);
        @(negedge clk); sel_byte = b; sel_valid = 1'b1;
        @(negedge clk); sel_valid = 1'b0;
    endtask
    task automatic strobe_addr(input logic msb);
        @(negedge clk); addr_msb = msb; addr_valid = 1'b1;
        @(negedge clk); addr_valid = 1'b0;
    endtask
    task automatic strobe_data();
        @(negedge clk); data_valid = 1'b1;
        @(negedge clk); data_valid = 1'b0;
    endtask
    task automatic strobe_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic sweep(input logic hv_lvl, input logic busy_lvl);
        hv = hv_lvl; busy = busy_lvl;
        for (int v = 0; v < 256; v++) begin
            logic e = exp_sel(v[7:0]);
            strobe_sel(v[7:0]);
            chk("R11 resp", resp, 1);
            if (busy_lvl)               chk("R1 busy noack", ack, e);
            else if (v[7:4] == 4'b1010) chk("R1 mem select", ack, e);
            else if (v[7:4] == 4'b0110 && v[0] && v[3:1] != 3'b110 &&
                     v[3:1] != 3'b111 && v[3:1] != 3'b011 && v[3:1] != 3'b010)
                                        chk("R6 query", ack, e);
            else if (v[7:4] == 4'b0110 && v[3:2] == 2'b11) chk("R7 page cmd", ack, e);
            else if (v[7:4] == 4'b0110 && !hv_lvl && !v[0]) chk("R4 no hv", ack, e);
            else                        chk("R9 reserved/other", ack, e);
            if (!busy_lvl && v[7:4] == 4'b0110 && !v[0] && v[3:1] == 3'b110) m_page = 1'b0;
            if (!busy_lvl && v[7:4] == 4'b0110 && !v[0] && v[3:1] == 3'b111) m_page = 1'b1;
            chk("R7 page", page, m_page);
            strobe_stop();
            chk("R10 no write without data", wr_req, 0);
            chk("R4 prot unchanged", prot, m_prot);
        end
        busy = 1'b0;
    endtask

    task automatic three_bytes(input string req, input logic [7:0] b, input logic msb, input logic e_sel, input logic e_a, input logic e_d);
        strobe_sel(b);   chk(req, ack, e_sel);
        strobe_addr(msb); chk(req, ack, e_a);
        strobe_data();   chk(req, ack, e_d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 reset page", page, 0);
        chk("R10 reset prot", prot, 0);
        chk("R11 reset resp", resp, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 no wr_req idle", wr_req, 0);

        sweep(1'b1, 1'b0);
        sweep(1'b0, 1'b0);
        sweep(1'b1, 1'b1);

        hv = 1'b1;
        for (int i = 0; i < 4; i++) begin
            three_bytes("R2 set ack", {4'b0110, blk_code(i), 1'b0}, 1'b0, 1, 1, 1);
            strobe_stop();
            chk("R2 wr_req", wr_req, 1);
            m_prot[i] = 1'b1;
            chk("R2 prot", prot, m_prot);
            for (int j = 0; j < 4; j++) begin
                strobe_sel({4'b0110, blk_code(j), 1'b1});
                chk("R6 query after set", ack, !m_prot[j]);
            end
        end
        three_bytes("R3 already protected", {4'b0110, blk_code(2), 1'b0}, 1'b1, 0, 0, 0);
        strobe_stop();
        chk("R3 no wr_req", wr_req, 0);

        three_bytes("R8 protected mem", {4'b1010, 3'b101, 1'b0}, 1'b0, 1, 1, 0);
        strobe_stop();
        chk("R8 no wr_req", wr_req, 0);

        hv = 1'b0;
        strobe_sel(8'h66); chk("R4 clear without hv", ack, 0);
        strobe_stop();     chk("R4 prot kept", prot, 4'hF);

        hv = 1'b1;
        three_bytes("R5 clear ack", 8'h66, 1'b0, 1, 1, 1);
        strobe_stop();
        chk("R5 wr_req", wr_req, 1);
        m_prot = 4'h0;
        chk("R5 prot cleared", prot, 0);

        strobe_sel(8'h6E); chk("R7 set page1", ack, 1);
        strobe_sel(8'h6D); chk("R7 read page1 noack", ack, 0);
        three_bytes("R2 set blk3", {4'b0110, blk_code(3), 1'b0}, 1'b0, 1, 1, 1);
        strobe_stop();
        m_prot[3] = 1'b1;
        three_bytes("R8 page1 msb1 protected", 8'hAA, 1'b1, 1, 1, 0);
        strobe_stop(); chk("R8 no wr_req", wr_req, 0);
        three_bytes("R8 page1 msb0 open", 8'hAA, 1'b0, 1, 1, 1);
        strobe_data(); chk("R8 second byte", ack, 1);
        strobe_stop(); chk("R8 wr_req", wr_req, 1);
        wc = 1'b1;
        three_bytes("R8 write control", 8'hAA, 1'b0, 1, 1, 0);
        strobe_stop(); chk("R8 wc no wr_req", wr_req, 0);
        wc = 1'b0;
        strobe_sel(8'hAB); chk("R1 mem read", ack, 1);
        strobe_sel(8'hA2); chk("R1 wrong address", ack, 0);
        strobe_sel(8'h6C); chk("R7 set page0", ack, 1);
        strobe_sel(8'h6D); chk("R7 read page0 ack", ack, 1);
        @(negedge clk);
        chk("R11 single pulse", resp, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule